// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between the memory stage of a 32-bit pipeline and a 32-bit-wide, byte-addressed data memory that stores multi-byte objects with the most significant byte at the lowest address. It forms the effective address by adding a sign-extended 16-bit displacement to a base register value. It presents the word address to memory, and for stores it steers the register data onto the correct byte lanes with matching per-byte write enables.

For loads, the unit remembers the byte offset, size and signedness of the accepted request. When memory returns the read word, it picks the addressed byte or halfword and sign- or zero-extends it into a 32-bit register value. The result is registered one cycle after the read data is valid. Any halfword or word access that does not fall on a multiple of its size is refused: no memory request, no write enables, and a one-cycle fault pulse.

Top module: `lsu_lane_top`

## Requirements
- R1: The effective address is `base + sign_extend(disp)`, modulo 2^32. `mem_addr` carries it with bits 1:0 forced to zero, in the same cycle as `req_valid`. `mem_req` is high exactly when `req_valid` is high and the access is aligned, and `mem_we` equals `mem_req & req_store`.
- R2: Size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word. Code 2'b11 behaves exactly as a word.
- R3: For an aligned store, `mem_be` bit 3 is the lane for byte offset 0 and bit 0 the lane for offset 3. A byte store drives 4'b1000 shifted right by the offset. A halfword store drives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store drives 4'b1111. `mem_be` is zero whenever no store is issued.
- R4: Store data goes out as follows. A byte store repeats `st_data[7:0]` on all four lanes. A halfword store repeats `st_data[15:0]` in both halves. A word store passes `st_data` unchanged.
- R5: A byte load returns memory bits [31-8*offset -: 8] in bits 7:0. Bits 31:8 copy bit 7 when `req_unsigned` is 0 and are zero when it is 1.
- R6: A halfword load returns `mem_rdata[31:16]` at offset 0 and `mem_rdata[15:0]` at offset 2 in bits 15:0. Bits 31:16 copy bit 15 when signed and are zero when unsigned.
- R7: A word load returns `mem_rdata` unchanged.
- R8: `ld_valid` is high for one cycle, the cycle after a cycle with `mem_rvalid` high, and `ld_data` holds the result during that cycle.
- R9: A halfword with address bit 0 set, or a word with address bits 1:0 non-zero, is misaligned. Such an access issues no memory request and no write enables, and `align_fault` is high for exactly the following cycle.
- R10: After reset, `ld_valid`, `ld_data` and `align_fault` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend load result |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 32 | Store register value |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte write enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read word from memory |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| align_fault | output | 1 | Misaligned-access pulse |

## Verification
The bench sweeps every byte offset with every size code, for both signed and unsigned loads and for stores, over three base/displacement pairs. One pair has a negative displacement and one pair carries across bit 15. The read-word patterns put a set top bit in some lanes and a clear top bit in others, so a wrong lane choice or a wrong extension shows up as a different value. Offsets 1 and 3 separate the halfword and word fault cases from the byte case, which never faults.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;

  // Alignment rule: halfwords need bit 0 clear, words need bits 1:0 clear.
  function automatic logic is_misaligned(size_e sz, logic [1:0] ofs);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return ofs[0];
      default: return |ofs;
    endcase
  endfunction

  // Byte write enables, bit 3 is the lowest address (big-endian lanes).
  function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [1:0] ofs);
    case (sz)
      SZ_BYTE: return 4'b1000 >> ofs;
      SZ_HALF: return ofs[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  // Replicate the low bits of the store value so every candidate lane holds it.
  function automatic logic [DATA_W-1:0] lane_spread(size_e sz, logic [DATA_W-1:0] d);
    case (sz)
      SZ_BYTE: return {LANES{d[7:0]}};
      SZ_HALF: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  // Select and extend the addressed object from a memory word.
  function automatic logic [DATA_W-1:0] lane_pick(size_e sz, logic [1:0] ofs,
                                                   logic uns, logic [DATA_W-1:0] w);
    logic [4:0]  sh;
    logic [7:0]  b;
    logic [15:0] h;
    case (sz)
      SZ_BYTE: begin
        sh = {2'd3 - ofs, 3'b000};
        b  = 8'(w >> sh);
        return {{24{b[7] & ~uns}}, b};
      end
      SZ_HALF: begin
        sh = ofs[1] ? 5'd0 : 5'd16;
        h  = 16'(w >> sh);
        return {{16{h[15] & ~uns}}, h};
      end
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea       = base + disp_ext;

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
(
  input  logic              issue,
  input  size_e             sz,
  input  logic [1:0]        ofs,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);

  assign be    = issue ? lane_mask(sz, ofs) : '0;
  assign wdata = lane_spread(sz, data);

  always_comb begin
    if (issue && sz == SZ_BYTE)
      AST_BYTE_ONE_LANE: assert ($onehot0(be) && be != '0); // R3
  end

endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  size_e             cap_sz,
  input  logic [1:0]        cap_ofs,
  input  logic              cap_uns,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  size_e      held_sz;
  logic [1:0] held_ofs;
  logic       held_uns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_sz  <= SZ_WORD;
      held_ofs <= '0;
      held_uns <= 1'b0;
    end else if (cap_en) begin
      held_sz  <= cap_sz;
      held_ofs <= cap_ofs;
      held_uns <= cap_uns;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= rvalid;
      if (rvalid) ld_data <= lane_pick(held_sz, held_ofs, held_uns, rdata);
    end
  end

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(rvalid)); // R8

  AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(held_sz) == SZ_BYTE && !$past(held_uns))
      |-> ld_data[31:8] == {24{ld_data[7]}}); // R5

  AST_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(held_sz) == SZ_HALF && $past(held_uns))
      |-> ld_data[31:16] == 16'h0); // R6

endmodule

// File: rtl/lsu_lane_top.sv
module lsu_lane_top
  import lsu_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] st_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              align_fault
);

  localparam int unsigned OFS_W = $clog2(LANES);

  logic [ADDR_W-1:0] ea;
  logic [OFS_W-1:0]  ofs;
  size_e             sz;
  logic              misaligned;
  logic              store_issue;
  logic              load_issue;

  lsu_ea_adder #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
    .base (base),
    .disp (disp),
    .ea   (ea)
  );

  assign sz          = size_e'(req_size);
  assign ofs         = ea[OFS_W-1:0];
  assign misaligned  = is_misaligned(sz, ofs);
  assign store_issue = req_valid & req_store & ~misaligned;
  assign load_issue  = req_valid & ~req_store & ~misaligned;

  assign mem_req  = store_issue | load_issue;
  assign mem_we   = store_issue;
  assign mem_addr = {ea[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  lsu_store_lanes u_st (
    .issue (store_issue),
    .sz    (sz),
    .ofs   (ofs),
    .data  (st_data),
    .be    (mem_be),
    .wdata (mem_wdata)
  );

  lsu_load_lanes u_ld (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (load_issue),
    .cap_sz   (sz),
    .cap_ofs  (ofs),
    .cap_uns  (req_unsigned),
    .rvalid   (mem_rvalid),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) align_fault <= 1'b0;
    else        align_fault <= req_valid & misaligned;
  end

  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && misaligned) |-> (!mem_req && mem_be == '0)); // R9

  AST_FAULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> ($past(req_valid) && $past(misaligned))); // R9

  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && sz == SZ_HALF) |-> $countones(mem_be) == 2); // R3

  AST_NO_BE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> mem_be == '0); // R3

endmodule

// File: tb/tb_lsu_lane_top.sv
`timescale 1ns/100ps
module tb_lsu_lane_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] base, st_data, mem_rdata;
  logic [15:0] disp;
  logic        mem_rvalid;
  logic        mem_req, mem_we, ld_valid, align_fault;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  lsu_lane_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .disp(disp),
    .st_data(st_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .align_fault(align_fault)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] calc_ea(logic [31:0] b, logic [15:0] d);
    int signed sd = int'($signed(d));
    return b + 32'(sd);
  endfunction

  function automatic bit calc_mis(int sz, int ofs);
    if (sz == 0) return 0;
    if (sz == 1) return (ofs % 2) != 0;
    return ofs != 0;
  endfunction

  function automatic logic [3:0] calc_be(int sz, int ofs);
    if (sz == 0) return 4'(1 << (3 - ofs));
    if (sz == 1) return (ofs < 2) ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  function automatic logic [31:0] calc_wdata(int sz, logic [31:0] d);
    if (sz == 0) return (d & 32'hFF) * 32'h0101_0101;
    if (sz == 1) return (d & 32'hFFFF) * 32'h0001_0001;
    return d;
  endfunction

  function automatic logic [31:0] calc_load(int sz, int ofs, bit uns, logic [31:0] w);
    logic [31:0] v;
    if (sz == 0) begin
      v = (w >> (8 * (3 - ofs))) & 32'hFF;
      if (!uns && v >= 32'd128) v = v | 32'hFFFF_FF00;
    end else if (sz == 1) begin
      v = (w >> ((ofs < 2) ? 16 : 0)) & 32'hFFFF;
      if (!uns && v >= 32'd32768) v = v | 32'hFFFF_0000;
    end else v = w;
    return v;
  endfunction

  function automatic string rsz(int sz);
    if (sz == 0) return "R5";
    if (sz == 1) return "R6";
    return "R7";
  endfunction

  task automatic run_store(logic [31:0] b, logic [15:0] d, int sz, logic [31:0] data);
    logic [31:0] ea = calc_ea(b, d);
    int ofs = int'(ea[1:0]);
    bit mis = calc_mis(sz, ofs);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = 2'(sz); req_unsigned = 0;
    base = b; disp = d; st_data = data;
    #1;
    chk("R1 addr", mem_addr, ea & 32'hFFFF_FFFC);
    chk("R1 req", {31'd0, mem_req}, {31'd0, !mis});
    chk("R1 we", {31'd0, mem_we}, {31'd0, !mis});
    chk(mis ? "R9 be" : (sz == 3 ? "R2 be" : "R3 be"), {28'd0, mem_be},
        mis ? 32'd0 : {28'd0, calc_be(sz, ofs)});
    if (!mis) chk("R4 wdata", mem_wdata, calc_wdata(sz, data));
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R9 fault", {31'd0, align_fault}, {31'd0, mis});
    @(negedge clk);
    #1;
    chk("R9 pulse end", {31'd0, align_fault}, 32'd0);
  endtask

  task automatic run_load(logic [31:0] b, logic [15:0] d, int sz, bit uns, logic [31:0] w);
    logic [31:0] ea = calc_ea(b, d);
    int ofs = int'(ea[1:0]);
    bit mis = calc_mis(sz, ofs);
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = 2'(sz); req_unsigned = uns;
    base = b; disp = d; st_data = 32'hDEAD_BEEF;
    #1;
    chk("R1 addr", mem_addr, ea & 32'hFFFF_FFFC);
    chk("R1 req", {31'd0, mem_req}, {31'd0, !mis});
    chk("R3 no be on load", {27'd0, mem_we, mem_be}, 32'd0);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R9 fault", {31'd0, align_fault}, {31'd0, mis});
    if (!mis) begin
      mem_rvalid = 1; mem_rdata = w;
      #0.5;
      chk("R8 not early", {31'd0, ld_valid}, 32'd0);
      @(negedge clk);
      mem_rvalid = 0; mem_rdata = 32'h0;
      #1;
      chk("R8 valid", {31'd0, ld_valid}, 32'd1);
      chk(sz == 3 ? "R2 data" : rsz(sz), ld_data, calc_load(sz, ofs, uns, w));
      chk("R9 pulse end", {31'd0, align_fault}, 32'd0);
      @(negedge clk);
      #1;
      chk("R8 one cycle", {31'd0, ld_valid}, 32'd0);
    end else begin
      @(negedge clk);
      #1;
      chk("R9 pulse end", {31'd0, align_fault}, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] bases [3] = '{32'h1000_0100, 32'h0000_8000, 32'hFFFF_FFF0};
    logic [15:0] disps [3] = '{16'h0004, 16'hFFF8, 16'h7FFC};
    logic [31:0] words [3] = '{32'h8123_45F7, 32'h7E5A_A17F, 32'hC0DE_0080};
    rst_n = 0; req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    base = 0; disp = 0; st_data = 0; mem_rvalid = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R10 ld_data", ld_data, 32'd0);
    chk("R10 fault", {31'd0, align_fault}, 32'd0);
    rst_n = 1;
    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 4; o++)
        for (int sz = 0; sz < 4; sz++) begin
          for (int u = 0; u < 2; u++)
            run_load(bases[p] + 32'(o), disps[p], sz, u[0], words[(p + o) % 3]);
          run_store(bases[p] + 32'(o), disps[p], sz, words[(p + sz) % 3]);
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule